// File: doc/BRIEF.md
# Sprite Table Page Copy Engine

This engine copies a fixed run of bytes from one 256-byte page of memory into the sprite attribute table, which sits at 0xFE00 to 0xFE9F. Software starts a copy by writing a page number to a single control register. The engine then waits through a short arming interval and moves one byte in each four-clock slot. Within a slot it first issues a read request on the source port. One cycle later it captures the returned byte. On the following cycle it raises a write strobe toward the table.

The destination keeps the low byte of the source address and replaces the high byte with 0xFE. While a copy is in flight the engine raises a busy flag. When a copy completes it gives a one-cycle done pulse. A second control write during a copy aborts that copy and starts a fresh one from the new page. The control register reads back the last byte written to it.

Top module: `sprite_dma`

## Requirements
- R1: After a control write of byte B, every source read address is {B, offset}, with the offset in the low 8 bits.
- R2: Every table write goes to address 0xFE00 | offset. It carries the byte that the memory returned for source address {B, offset}.
- R3: The write edge that samples `cfg_we_i` high is cycle 0. The first `rd_req_o` is high in cycle 4, and after that `rd_req_o` is high in every cycle 4+4k and in no other cycle.
- R4: Read data is sampled one cycle after `rd_req_o`. The matching `wr_en_o` is high two cycles after the read request, and `rd_req_o` and `wr_en_o` are never high in the same cycle.
- R5: A complete run makes exactly 160 table writes, with offsets 0x00 through 0x9F in ascending order.
- R6: `busy_o` is high in cycles 0 through 643 after the control write and low at every other time.
- R7: `done_o` is high for exactly one cycle, cycle 644, and only after a run that completed. No request or strobe is issued while idle.
- R8: A control write while busy restarts the run from offset 0x00 with the new page, using the cycle numbering of R3. The aborted run never produces `done_o`, even when the write lands in its final cycle.
- R9: `cfg_rdata_o` shows the last byte written to the control register.
- R10: After reset, `busy_o`, `done_o`, `rd_req_o`, `wr_en_o` and `cfg_rdata_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control register write enable |
| cfg_wdata_i | input | 8 | Source page number |
| cfg_rdata_o | output | 8 | Last written page number |
| rd_req_o | output | 1 | Source read request |
| rd_addr_o | output | 16 | Source read address |
| rd_data_i | input | 8 | Source read data, valid one cycle after the request |
| wr_en_o | output | 1 | Table write strobe |
| wr_addr_o | output | 16 | Table write address |
| wr_data_o | output | 8 | Table write data |
| busy_o | output | 1 | Arming or copying |
| done_o | output | 1 | One-cycle pulse when a run completes |

## Verification
The hardest case to reach is a control write that lands in the very last cycle of a run. That write races the completion pulse, and the pulse must lose. The bench counts cycles from each control write and waits until the count reaches 643. It then raises the write enable so that the same edge which would end the run samples the write instead. The bench also restarts a run in the middle of a copy. In both cases the per-cycle monitor expects no done pulse, and it expects the new run's reads and writes to start from offset 0x00 on the fresh timeline.

// File: rtl/sprite_dma_pkg.sv
package sprite_dma_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_ARM  = 2'd1,
    ST_MOVE = 2'd2
  } dma_state_e;
endpackage

// File: rtl/dma_seq.sv
module dma_seq
  import sprite_dma_pkg::*;
#(
  parameter int unsigned STARTUP   = 4,
  parameter int unsigned SLOT_CLKS = 4,
  parameter int unsigned XFER_LEN  = 160
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic rd_slot_o,
  output logic cap_slot_o,
  output logic wr_slot_o,
  output logic done_o
);
  localparam int unsigned RUN_CYC = STARTUP + XFER_LEN * SLOT_CLKS;
  localparam int unsigned CNT_W   = $clog2(RUN_CYC + 1);
  localparam int unsigned PH_W    = $clog2(SLOT_CLKS);

  dma_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PH_W-1:0]  ph_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
      ph_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        // restart wins over completion in the same cycle
        state_q <= ST_ARM;
        cnt_q   <= '0;
        ph_q    <= '0;
      end else begin
        case (state_q)
          ST_ARM: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(STARTUP - 1)) state_q <= ST_MOVE;
          end
          ST_MOVE: begin
            ph_q <= ph_q + 1'b1;
            if (cnt_q == CNT_W'(RUN_CYC - 1)) begin
              state_q <= ST_OFF;
              cnt_q   <= '0;
              done_q  <= 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign busy_o     = (state_q != ST_OFF);
  assign rd_slot_o  = (state_q == ST_MOVE) && (ph_q == PH_W'(0));
  assign cap_slot_o = (state_q == ST_MOVE) && (ph_q == PH_W'(1));
  assign wr_slot_o  = (state_q == ST_MOVE) && (ph_q == PH_W'(2));
  assign done_o     = done_q;
endmodule

// File: rtl/dma_addr.sv
module dma_addr #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned OFF_W     = 8,
  parameter int unsigned DEST_PAGE = 'hFE
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clear_i,
  input  logic                    step_i,
  input  logic [ADDR_W-OFF_W-1:0] page_i,
  output logic [ADDR_W-1:0]       rd_addr_o,
  output logic [ADDR_W-1:0]       wr_addr_o
);
  localparam int unsigned PAGE_W = ADDR_W - OFF_W;

  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      off_q <= '0;
    else if (clear_i) off_q <= '0;
    else if (step_i)  off_q <= off_q + 1'b1;
  end

  assign rd_addr_o = {page_i, off_q};
  assign wr_addr_o = {PAGE_W'(DEST_PAGE), off_q};
endmodule

// File: rtl/dma_buf.sv
module dma_buf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (cap_i) q_o <= d_i;
  end
endmodule

// File: rtl/sprite_dma.sv
module sprite_dma #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned OFF_W     = 8,
  parameter int unsigned XFER_LEN  = 160,
  parameter int unsigned STARTUP   = 4,
  parameter int unsigned SLOT_CLKS = 4,
  parameter int unsigned DEST_PAGE = 'hFE
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cfg_we_i,
  input  logic [ADDR_W-OFF_W-1:0] cfg_wdata_i,
  output logic [ADDR_W-OFF_W-1:0] cfg_rdata_o,
  output logic                    rd_req_o,
  output logic [ADDR_W-1:0]       rd_addr_o,
  input  logic [DATA_W-1:0]       rd_data_i,
  output logic                    wr_en_o,
  output logic [ADDR_W-1:0]       wr_addr_o,
  output logic [DATA_W-1:0]       wr_data_o,
  output logic                    busy_o,
  output logic                    done_o
);
  localparam int unsigned PAGE_W = ADDR_W - OFF_W;

  logic [PAGE_W-1:0] ctrl_q;
  logic              cap_slot, wr_slot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctrl_q <= '0;
    else if (cfg_we_i) ctrl_q <= cfg_wdata_i;
  end
  assign cfg_rdata_o = ctrl_q;

  dma_seq #(
    .STARTUP  (STARTUP),
    .SLOT_CLKS(SLOT_CLKS),
    .XFER_LEN (XFER_LEN)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (cfg_we_i),
    .busy_o    (busy_o),
    .rd_slot_o (rd_req_o),
    .cap_slot_o(cap_slot),
    .wr_slot_o (wr_slot),
    .done_o    (done_o)
  );

  dma_addr #(
    .ADDR_W   (ADDR_W),
    .OFF_W    (OFF_W),
    .DEST_PAGE(DEST_PAGE)
  ) u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (cfg_we_i),
    .step_i   (wr_slot),
    .page_i   (ctrl_q),
    .rd_addr_o(rd_addr_o),
    .wr_addr_o(wr_addr_o)
  );

  dma_buf #(
    .DATA_W(DATA_W)
  ) u_buf (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap_i (cap_slot),
    .d_i   (rd_data_i),
    .q_o   (wr_data_o)
  );

  assign wr_en_o = wr_slot;
endmodule

// File: rtl/sprite_dma_chk.sv
module sprite_dma_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_we_i,
  input logic       rd_req_o,
  input logic [7:0] rd_lo_i,
  input logic       wr_en_o,
  input logic [7:0] wr_lo_i,
  input logic       busy_o,
  input logic       done_o
);
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))); // R6
  AST_WR_FOLLOWS_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(rd_req_o, 2)); // R4
  AST_WR_KEEPS_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_lo_i == $past(rd_lo_i, 2))); // R2
  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && wr_en_o)); // R4
  AST_RD_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o || wr_en_o) |-> busy_o); // R7
  AST_START_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (busy_o && !done_o)); // R8
endmodule

bind sprite_dma sprite_dma_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cfg_we_i(cfg_we_i),
  .rd_req_o(rd_req_o),
  .rd_lo_i (rd_addr_o[7:0]),
  .wr_en_o (wr_en_o),
  .wr_lo_i (wr_addr_o[7:0]),
  .busy_o  (busy_o),
  .done_o  (done_o)
);

// File: tb/tb_sprite_dma.sv
`timescale 1ns/1ps
module tb_sprite_dma;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_wdata_i = '0;
  logic [7:0]  cfg_rdata_o;
  logic        rd_req_o;
  logic [15:0] rd_addr_o;
  logic [7:0]  rd_data_i = '0;
  logic        wr_en_o;
  logic [15:0] wr_addr_o;
  logic [7:0]  wr_data_o;
  logic        busy_o;
  logic        done_o;

  sprite_dma dut (.*);

  always #4 clk_i = ~clk_i; // 125 MHz

  int n_chk = 0, n_bad = 0;
  int rel = 1000;
  bit armed = 1'b0;
  logic [7:0] pg = '0;
  int wcnt = 0, dones = 0;
  bit fin = 1'b0;

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return 8'((a[7:0] * 7) + (a[15:8] * 13) + 5);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h rel=%0d", req, act, exp, rel);
    end
  endtask

  // source memory: one-cycle read latency
  always @(posedge clk_i) if (rd_req_o) rd_data_i <= mem_f(rd_addr_o);

  // cycle index relative to the last control write edge
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel <= 1000; armed <= 1'b0; pg <= '0;
    end else if (cfg_we_i) begin
      rel <= 0; armed <= 1'b1; pg <= cfg_wdata_i;
    end else begin
      rel <= rel + 1;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !fin) begin
      bit eb, ed, er, ew;
      if (rel == 0) wcnt = 0;
      eb = armed && rel <= 643;
      ed = armed && rel == 644;
      er = armed && rel >= 4 && rel <= 643 && ((rel - 4) % 4 == 0);
      ew = armed && rel >= 6 && rel <= 643 && ((rel - 6) % 4 == 0);
      chk(busy_o == eb, "R6 busy", busy_o, eb);
      chk(done_o == ed, "R7 done", done_o, ed);
      chk(rd_req_o == er, "R3 rd_req", rd_req_o, er);
      chk(wr_en_o == ew, "R4 wr_en", wr_en_o, ew);
      if (er) chk(rd_addr_o == {pg, 8'((rel - 4) / 4)}, "R1 rd_addr", rd_addr_o, {pg, 8'((rel - 4) / 4)});
      if (ew) begin
        chk(wr_addr_o == (16'hFE00 | 16'((rel - 6) / 4)), "R2 wr_addr", wr_addr_o, 16'hFE00 | 16'((rel - 6) / 4));
        chk(wr_data_o == mem_f({pg, 8'((rel - 6) / 4)}), "R2 wr_data", wr_data_o, mem_f({pg, 8'((rel - 6) / 4)}));
        wcnt++;
      end
      if (ed) begin
        chk(wcnt == 160, "R5 write count", wcnt, 160);
        dones++;
      end
    end
  end

  task automatic write_cfg(input logic [7:0] b);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_wdata_i = b;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    chk(cfg_rdata_o == b, "R9 readback", cfg_rdata_o, b);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog act=0 exp=1");
    fin = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !rd_req_o && !wr_en_o, "R10 reset outputs", {busy_o, done_o, rd_req_o, wr_en_o}, 0);
    chk(cfg_rdata_o == 8'h00, "R9 reset readback", cfg_rdata_o, 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    chk(!busy_o && !rd_req_o && !wr_en_o, "R10 idle after reset", {busy_o, rd_req_o, wr_en_o}, 0);
    // full runs over several pages
    foreach (cfg_wdata_i[i]) ; // no-op keeps loop vars local
    for (int p = 0; p < 4; p++) begin
      logic [7:0] pages [4] = '{8'h00, 8'hAB, 8'hFF, 8'h12};
      write_cfg(pages[p]);
      repeat (700) @(negedge clk_i);
    end
    // R8: restart mid-copy
    write_cfg(8'h34);
    repeat (200) @(negedge clk_i);
    write_cfg(8'h56);
    repeat (700) @(negedge clk_i);
    // R8: restart in the final cycle of a run
    write_cfg(8'h77);
    while (rel != 643) @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_wdata_i = 8'h88;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    chk(!done_o, "R8 no done on abort", done_o, 0);
    chk(cfg_rdata_o == 8'h88, "R9 readback", cfg_rdata_o, 8'h88);
    repeat (700) @(negedge clk_i);
    chk(dones == 6, "R8 done count", dones, 6);
    chk(!busy_o, "R7 idle at end", busy_o, 0);
    fin = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule